// File: doc/BRIEF.md
# Operand Register File with Peek Stack and Side Registers

This block stores operands for an 8-bit datapath and supplies both input sides of an ALU at once. It holds six general registers, two side registers, a six-entry last-in first-out stack and a flag register. Each operand side chooses its source with its own 3-bit code, and the result of an operation goes back through a 3-bit destination code. The ALU, the instruction decoder and the I/O unit are outside the block. They see only combinational operand outputs and the registered write, pop and load controls.

Each side register is wired to one operand side only. An immediate or I/O-read load picks one side register, the other, or both. Loading both makes the value readable from either side. The stack has no read port that removes data. Reading code 111 returns the current top and leaves the stack as it is. A separate pop bit, which comes with each operation, discards the top after that operation's write. Asserting the pop bit while reading the top therefore gives a true pop.

Top module: `opnd_regfile`

## Requirements
- R1: Read codes 001 to 110 return general registers 1 to 6. Both sides may read the same register or different registers in one cycle. A write with `wr_en` and a destination code from 001 to 110 is visible on the next cycle.
- R2: Read code 000 returns the first side register on side A and the second side register on side B. No side register is ever visible on the other side.
- R3: When `spr_we` bit 0 is high, `spr_din` is stored into the first side register. When bit 1 is high, it is stored into the second. With 2'b11 the same value can be read through code 000 on both sides. A side register that is not selected keeps its value.
- R4: Read code 111 returns the stack top and does not remove it, so repeated reads return the same value. An empty stack reads as 8'h00.
- R5: A write with destination code 111 and `pop` low pushes `wr_data`. It becomes the top on the next cycle.
- R6: When `pop` is high, the top entry is discarded after that cycle's write, whether `wr_en` is high or low. A top read in the same cycle still returns the old top. The next entry is the top on the following cycle.
- R7: A push and a pop in the same cycle leave the stack contents and depth unchanged and set no flag, even on a full stack.
- R8: A write to destination code 000 changes no general register, side register or stack entry.
- R9: When `flag_ld` is high, `flag_in` is stored into the flag register. While `flag_sel_a` is high, side A outputs the flag register instead of the source chosen by its code.
- R10: A push onto a stack that already holds six entries drops the oldest entry, makes the new value the top, and sets `stk_ovf`. The flag stays set until reset.
- R11: A pop (without push) of an empty stack sets `stk_unf`, which stays set until reset, and changes nothing else.
- R12: A synchronous active-high `rst` clears all general registers, both side registers, the flag register, the stack and both sticky flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_code | input | 3 | Side A source code |
| rd_b_code | input | 3 | Side B source code |
| flag_sel_a | input | 1 | Put the flag register on side A |
| wr_en | input | 1 | Result write enable |
| wr_code | input | 3 | Result destination code |
| wr_data | input | 8 | Result value |
| pop | input | 1 | Discard the stack top after this cycle's write |
| spr_we | input | 2 | Side register load select (bit 0 first, bit 1 second) |
| spr_din | input | 8 | Immediate or I/O value for the side registers |
| flag_ld | input | 1 | Load the flag register |
| flag_in | input | 8 | External status flags |
| opnd_a | output | 8 | Side A operand |
| opnd_b | output | 8 | Side B operand |
| stk_ovf | output | 1 | Sticky stack overflow |
| stk_unf | output | 1 | Sticky stack underflow |

## Verification
The properties assume that every control input is a clean 0 or 1 in every cycle after reset. They also assume that a push is recognised only from `wr_en` together with destination code 111, so a code-111 write with `wr_en` low must not move the stack. The stimulus drives every input at the falling edge and holds it until the next falling edge. It keeps every control low on cycles that are not meant to act. Stack depth is changed only through the push and pop controls, so each depth property sees a single operation per cycle, which is how the block is meant to be used.

// File: rtl/opnd_pkg.sv
package opnd_pkg;

    localparam int CODE_W = 3;
    localparam int NGPR   = (1 << CODE_W) - 2;
    localparam int NSIDE  = 2;

    localparam logic [CODE_W-1:0] CODE_SPR = '0;
    localparam logic [CODE_W-1:0] CODE_STK = '1;

    typedef enum logic [1:0] {
        STK_HOLD    = 2'd0,
        STK_PUSH    = 2'd1,
        STK_POP     = 2'd2,
        STK_PUSHPOP = 2'd3
    } stk_op_e;

    typedef struct packed {
        logic              en;
        logic [CODE_W-1:0] code;
    } dst_t;

    function automatic logic is_gpr(input logic [CODE_W-1:0] c);
        return (c != CODE_SPR) && (c != CODE_STK);
    endfunction

    function automatic stk_op_e stk_decode(input logic push, input logic pop);
        case ({push, pop})
            2'b10:   return STK_PUSH;
            2'b01:   return STK_POP;
            2'b11:   return STK_PUSHPOP;
            default: return STK_HOLD;
        endcase
    endfunction

endpackage

// File: rtl/opnd_gpr_bank.sv
module opnd_gpr_bank
    import opnd_pkg::*;
#(
    parameter int DW  = 8,
    parameter int NRD = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  dst_t                       dst,
    input  logic [DW-1:0]              wr_data,
    input  logic [NRD-1:0][CODE_W-1:0] rd_code,
    output logic [NRD-1:0][DW-1:0]     rd_data
);

    logic [DW-1:0] regs [NGPR];

    for (genvar g = 0; g < NGPR; g++) begin : g_reg
        localparam logic [CODE_W-1:0] MY_CODE = CODE_W'(g + 1);
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= '0;
            end else if (dst.en && is_gpr(dst.code) && (dst.code == MY_CODE)) begin
                regs[g] <= wr_data;
            end
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_port
        always_comb begin
            rd_data[p] = '0;
            for (int i = 0; i < NGPR; i++) begin
                if (rd_code[p] == CODE_W'(i + 1)) begin
                    rd_data[p] = regs[i];
                end
            end
        end
    end

endmodule

// File: rtl/opnd_hw_stack.sv
module opnd_hw_stack
    import opnd_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 6,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  logic [DW-1:0]    push_data,
    output logic [DW-1:0]    top,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf,
    output logic             unf
);

    logic [DW-1:0] ent [DEPTH];
    stk_op_e       op;
    logic          full;
    logic          empty;

    assign op    = stk_decode(push, pop);
    assign full  = (cnt == CNT_W'(DEPTH));
    assign empty = (cnt == '0);
    assign top   = empty ? '0 : ent[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
            cnt <= '0;
            ovf <= 1'b0;
            unf <= 1'b0;
        end else begin
            case (op)
                STK_PUSH: begin
                    ent[0] <= push_data;
                    for (int i = 1; i < DEPTH; i++) ent[i] <= ent[i-1];
                    if (full) ovf <= 1'b1;
                    else      cnt <= cnt + 1'b1;
                end
                STK_POP: begin
                    if (empty) begin
                        unf <= 1'b1;
                    end else begin
                        for (int i = 0; i < DEPTH - 1; i++) ent[i] <= ent[i+1];
                        ent[DEPTH-1] <= '0;
                        cnt <= cnt - 1'b1;
                    end
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/opnd_side_sel.sv
module opnd_side_sel
    import opnd_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [CODE_W-1:0] code,
    input  logic              flag_sel,
    input  logic [DW-1:0]     spr,
    input  logic [DW-1:0]     gpr,
    input  logic [DW-1:0]     stk_top,
    input  logic [DW-1:0]     flags,
    output logic [DW-1:0]     opnd
);

    always_comb begin
        if (flag_sel)               opnd = flags;
        else if (code == CODE_SPR)  opnd = spr;
        else if (code == CODE_STK)  opnd = stk_top;
        else                        opnd = gpr;
    end

endmodule

// File: rtl/opnd_regfile.sv
module opnd_regfile
    import opnd_pkg::*;
#(
    parameter int DW        = 8,
    parameter int STK_DEPTH = 6,
    localparam int CNT_W    = $clog2(STK_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] rd_a_code,
    input  logic [CODE_W-1:0] rd_b_code,
    input  logic              flag_sel_a,
    input  logic              wr_en,
    input  logic [CODE_W-1:0] wr_code,
    input  logic [DW-1:0]     wr_data,
    input  logic              pop,
    input  logic [NSIDE-1:0]  spr_we,
    input  logic [DW-1:0]     spr_din,
    input  logic              flag_ld,
    input  logic [DW-1:0]     flag_in,
    output logic [DW-1:0]     opnd_a,
    output logic [DW-1:0]     opnd_b,
    output logic              stk_ovf,
    output logic              stk_unf
);

    dst_t                        dst;
    logic [NSIDE-1:0][CODE_W-1:0] side_code;
    logic [NSIDE-1:0][DW-1:0]     side_gpr;
    logic [NSIDE-1:0][DW-1:0]     side_opnd;
    logic [NSIDE-1:0]             side_flag_sel;
    logic [DW-1:0]                spr_q [NSIDE];
    logic [DW-1:0]                flag_q;
    logic [DW-1:0]                stk_top;
    logic [CNT_W-1:0]             stk_cnt;
    logic                         push;

    assign dst.en   = wr_en;
    assign dst.code = wr_code;
    assign push     = wr_en && (wr_code == CODE_STK);

    assign side_code[0]     = rd_a_code;
    assign side_code[1]     = rd_b_code;
    assign side_flag_sel[0] = flag_sel_a;
    assign side_flag_sel[1] = 1'b0;
    assign opnd_a           = side_opnd[0];
    assign opnd_b           = side_opnd[1];

    opnd_gpr_bank #(.DW(DW), .NRD(NSIDE)) u_gpr (
        .clk     (clk),
        .rst     (rst),
        .dst     (dst),
        .wr_data (wr_data),
        .rd_code (side_code),
        .rd_data (side_gpr)
    );

    opnd_hw_stack #(.DW(DW), .DEPTH(STK_DEPTH)) u_stk (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .pop       (pop),
        .push_data (wr_data),
        .top       (stk_top),
        .cnt       (stk_cnt),
        .ovf       (stk_ovf),
        .unf       (stk_unf)
    );

    always_ff @(posedge clk) begin
        if (rst)          flag_q <= '0;
        else if (flag_ld) flag_q <= flag_in;
    end

    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        always_ff @(posedge clk) begin
            if (rst)            spr_q[s] <= '0;
            else if (spr_we[s]) spr_q[s] <= spr_din;
        end

        opnd_side_sel #(.DW(DW)) u_sel (
            .code     (side_code[s]),
            .flag_sel (side_flag_sel[s]),
            .spr      (spr_q[s]),
            .gpr      (side_gpr[s]),
            .stk_top  (stk_top),
            .flags    (flag_q),
            .opnd     (side_opnd[s])
        );
    end

endmodule

// File: rtl/opnd_regfile_chk.sv
module opnd_regfile_chk
    import opnd_pkg::*;
#(
    parameter int DW        = 8,
    parameter int STK_DEPTH = 6,
    localparam int CNT_W    = $clog2(STK_DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic [CODE_W-1:0] rd_a_code,
    input logic [CODE_W-1:0] rd_b_code,
    input logic              flag_sel_a,
    input logic              wr_en,
    input logic [CODE_W-1:0] wr_code,
    input logic [DW-1:0]     wr_data,
    input logic              pop,
    input logic [NSIDE-1:0]  spr_we,
    input logic [DW-1:0]     spr_din,
    input logic [DW-1:0]     opnd_a,
    input logic [DW-1:0]     opnd_b,
    input logic              stk_ovf,
    input logic              stk_unf,
    input logic [DW-1:0]     stk_top,
    input logic [CNT_W-1:0]  stk_cnt
);

    logic push_c;
    assign push_c = wr_en && (wr_code == CODE_STK);

    // R10
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        stk_ovf |=> stk_ovf);

    // R11
    unf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        stk_unf |=> stk_unf);

    // R10
    ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
        (push_c && !pop && stk_cnt == CNT_W'(STK_DEPTH)) |=> stk_ovf);

    // R11
    unf_set_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && !push_c && stk_cnt == '0) |=> (stk_unf && stk_cnt == '0));

    // R10
    depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
        stk_cnt <= CNT_W'(STK_DEPTH));

    // R5
    push_top_chk: assert property (@(posedge clk) disable iff (rst)
        (push_c && !pop) |=> (stk_top == $past(wr_data)));

    // R7
    push_pop_cancel_chk: assert property (@(posedge clk) disable iff (rst)
        (push_c && pop) |=> ($stable(stk_cnt) && $stable(stk_top)));

    // R6
    pop_depth_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && !push_c && stk_cnt != '0) |=> (stk_cnt == $past(stk_cnt) - 1'b1));

    // R3
    spr_a_load_chk: assert property (@(posedge clk) disable iff (rst)
        spr_we[0] |=> (rd_a_code != CODE_SPR || flag_sel_a || opnd_a == $past(spr_din)));

    // R3
    spr_b_load_chk: assert property (@(posedge clk) disable iff (rst)
        spr_we[1] |=> (rd_b_code != CODE_SPR || opnd_b == $past(spr_din)));

endmodule

bind opnd_regfile opnd_regfile_chk #(.DW(DW), .STK_DEPTH(STK_DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rd_a_code  (rd_a_code),
    .rd_b_code  (rd_b_code),
    .flag_sel_a (flag_sel_a),
    .wr_en      (wr_en),
    .wr_code    (wr_code),
    .wr_data    (wr_data),
    .pop        (pop),
    .spr_we     (spr_we),
    .spr_din    (spr_din),
    .opnd_a     (opnd_a),
    .opnd_b     (opnd_b),
    .stk_ovf    (stk_ovf),
    .stk_unf    (stk_unf),
    .stk_top    (stk_top),
    .stk_cnt    (stk_cnt)
);

// File: tb/opnd_regfile_bench.sv
module opnd_regfile_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] rd_a_code, rd_b_code, wr_code;
    logic       flag_sel_a, wr_en, pop, flag_ld;
    logic [7:0] wr_data, spr_din, flag_in;
    logic [1:0] spr_we;
    logic [7:0] opnd_a, opnd_b;
    logic       stk_ovf, stk_unf;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    opnd_regfile u_opnd_regfile (
        .clk(clk), .rst(rst), .rd_a_code(rd_a_code), .rd_b_code(rd_b_code),
        .flag_sel_a(flag_sel_a), .wr_en(wr_en), .wr_code(wr_code), .wr_data(wr_data),
        .pop(pop), .spr_we(spr_we), .spr_din(spr_din), .flag_ld(flag_ld),
        .flag_in(flag_in), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .stk_ovf(stk_ovf), .stk_unf(stk_unf)
    );

    // vector: {we, wcode, wdata, pop, ra, rb, exp_a, exp_b}; expected values read the
    // state left by earlier vectors, sampled before this vector's clock edge
    localparam int NV = 14;
    localparam logic [34:0] VT [NV] = '{
        {1'b1, 3'd1, 8'h11, 1'b0, 3'd1, 3'd2, 8'h00, 8'h00},
        {1'b1, 3'd2, 8'h22, 1'b0, 3'd1, 3'd1, 8'h11, 8'h11},
        {1'b1, 3'd6, 8'h66, 1'b0, 3'd2, 3'd1, 8'h22, 8'h11},
        {1'b1, 3'd0, 8'hFF, 1'b0, 3'd6, 3'd2, 8'h66, 8'h22},
        {1'b1, 3'd7, 8'hA1, 1'b0, 3'd7, 3'd6, 8'h00, 8'h66},
        {1'b1, 3'd7, 8'hB2, 1'b0, 3'd7, 3'd7, 8'hA1, 8'hA1},
        {1'b0, 3'd0, 8'h00, 1'b0, 3'd7, 3'd1, 8'hB2, 8'h11},
        {1'b0, 3'd0, 8'h00, 1'b0, 3'd7, 3'd2, 8'hB2, 8'h22},
        {1'b1, 3'd3, 8'h33, 1'b1, 3'd7, 3'd3, 8'hB2, 8'h00},
        {1'b0, 3'd0, 8'h00, 1'b0, 3'd7, 3'd3, 8'hA1, 8'h33},
        {1'b1, 3'd7, 8'hC3, 1'b1, 3'd7, 3'd0, 8'hA1, 8'h00},
        {1'b0, 3'd0, 8'h00, 1'b0, 3'd7, 3'd1, 8'hA1, 8'h11},
        {1'b0, 3'd0, 8'h00, 1'b1, 3'd7, 3'd6, 8'hA1, 8'h66},
        {1'b0, 3'd0, 8'h00, 1'b0, 3'd7, 3'd4, 8'h00, 8'h00}
    };
    string vtag [NV];

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        wr_en = 1'b0; wr_code = 3'd0; wr_data = 8'h00; pop = 1'b0;
        spr_we = 2'b00; spr_din = 8'h00; flag_ld = 1'b0; flag_in = 8'h00;
        flag_sel_a = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        vtag = '{"R12 reset reads", "R1 same reg both sides", "R1 two regs",
                 "R8 code 000 write", "R4 empty stack", "R5 push top",
                 "R4 peek keeps top", "R4 repeated peek", "R6 read during pop",
                 "R6 next entry visible", "R7 push+pop", "R7 stack unchanged",
                 "R6 pop without write", "R4 drained stack"};
        idle();
        rd_a_code = 3'd0; rd_b_code = 3'd0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #5;
        chk("R12 ovf after reset", {7'd0, stk_ovf}, 8'h00);
        chk("R12 unf after reset", {7'd0, stk_unf}, 8'h00);
        chk("R12 spr1 after reset", opnd_a, 8'h00);

        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            wr_en     = VT[k][34];
            wr_code   = VT[k][33:31];
            wr_data   = VT[k][30:23];
            pop       = VT[k][22];
            rd_a_code = VT[k][21:19];
            rd_b_code = VT[k][18:16];
            #5;
            chk({vtag[k], " side A"}, opnd_a, VT[k][15:8]);
            chk({vtag[k], " side B"}, opnd_b, VT[k][7:0]);
        end
        @(negedge clk);
        idle();
        #5;
        chk("R11 no underflow from table", {7'd0, stk_unf}, 8'h00);

        // side registers
        @(negedge clk);
        spr_we = 2'b01; spr_din = 8'h3C; rd_a_code = 3'd0; rd_b_code = 3'd0;
        @(negedge clk);
        spr_we = 2'b10; spr_din = 8'hC5;
        #5;
        chk("R3 spr1 loaded", opnd_a, 8'h3C);
        chk("R2 spr1 hidden on B", opnd_b, 8'h00);
        @(negedge clk);
        spr_we = 2'b11; spr_din = 8'h99;
        #5;
        chk("R2 spr2 hidden on A", opnd_a, 8'h3C);
        chk("R3 spr2 loaded", opnd_b, 8'hC5);
        @(negedge clk);
        spr_we = 2'b00;
        #5;
        chk("R3 both loaded A", opnd_a, 8'h99);
        chk("R3 both loaded B", opnd_b, 8'h99);

        // flag register
        @(negedge clk);
        flag_ld = 1'b1; flag_in = 8'h5A; rd_a_code = 3'd1; rd_b_code = 3'd1;
        @(negedge clk);
        flag_ld = 1'b0; flag_sel_a = 1'b1;
        #5;
        chk("R9 flags on A", opnd_a, 8'h5A);
        chk("R9 B unaffected", opnd_b, 8'h11);
        @(negedge clk);
        flag_sel_a = 1'b0;
        #5;
        chk("R9 A back to code", opnd_a, 8'h11);

        // overflow
        for (int v = 1; v <= 7; v++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_code = 3'd7; wr_data = 8'(v);
            #5;
            if (v == 7) chk("R10 no ovf before seventh push", {7'd0, stk_ovf}, 8'h00);
        end
        @(negedge clk);
        idle(); rd_a_code = 3'd7;
        #5;
        chk("R10 ovf set", {7'd0, stk_ovf}, 8'h01);
        chk("R10 new top", opnd_a, 8'h07);
        for (int p = 0; p < 5; p++) begin
            @(negedge clk);
            pop = 1'b1;
        end
        @(negedge clk);
        pop = 1'b0;
        #5;
        chk("R10 oldest dropped", opnd_a, 8'h02);
        @(negedge clk);
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
        #5;
        chk("R4 empty after drain", opnd_a, 8'h00);
        chk("R11 no unf yet", {7'd0, stk_unf}, 8'h00);

        // underflow
        @(negedge clk);
        pop = 1'b1; rd_b_code = 3'd1;
        @(negedge clk);
        pop = 1'b0;
        #5;
        chk("R11 unf set", {7'd0, stk_unf}, 8'h01);
        chk("R11 top unchanged", opnd_a, 8'h00);
        chk("R11 reg unchanged", opnd_b, 8'h11);
        chk("R10 ovf still set", {7'd0, stk_ovf}, 8'h01);
        @(negedge clk);
        #5;
        chk("R11 unf sticky", {7'd0, stk_unf}, 8'h01);

        // reset again
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0; rd_a_code = 3'd1; rd_b_code = 3'd0;
        #5;
        chk("R12 reg cleared", opnd_a, 8'h00);
        chk("R12 spr2 cleared", opnd_b, 8'h00);
        chk("R12 ovf cleared", {7'd0, stk_ovf}, 8'h00);
        chk("R12 unf cleared", {7'd0, stk_unf}, 8'h00);
        @(negedge clk);
        flag_sel_a = 1'b1;
        #5;
        chk("R12 flags cleared", opnd_a, 8'h00);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule